// File: doc/BRIEF.md
# Two-Level Register Write Protection

This block keeps a small bank of 32-bit configuration registers behind a simple register write port, and guards each one with its own soft lock bit. While a register's soft lock is set, writes to its contents are refused. A soft lock moves only when the same write also raises the matching enable bit. It can be applied or released this way, either through a shared lock register or through two fields at the top of registers built with inline lock fields. A single hard lock sits above all soft locks. Once set, it freezes every soft lock at its current value until reset.

The hard lock is a two-state machine. `SEAL_OPEN` is the reset state, where soft locks may change. A write of 1 to bit 0 of the protection register takes the transition `SEAL_OPEN -> SEAL_SHUT`. In `SEAL_SHUT` the only transition is `SEAL_SHUT -> SEAL_SHUT`, and only reset returns the machine to `SEAL_OPEN`. Whenever a write is refused, `wr_rejected` pulses for one cycle and no state changes. The register contents are always visible on `cfg_data` and can be read back through a combinational read port.

Address map (NUM_REGS = N): addresses 0 to N-1 are the configuration registers, address N is the lock register, and address N+1 is the protection register.

Top module: `regprot_top`

## Requirements
- R1: A write to configuration register i while its soft lock is 1 leaves every register unchanged and is refused.
- R2: In the lock register, bit i holds soft lock i and bit 16+i is its enable. On read, bits [N-1:0] return the lock values and every enable bit reads 0.
- R3: A write that leaves a soft lock's enable bit at 0 leaves that lock unchanged, whatever value it carries for the lock.
- R4: In `SEAL_OPEN`, a write with enable bit i set loads soft lock i with the written value: 1 applies the lock and 0 releases it.
- R5: In registers with inline lock fields (INLINE_MASK bit set, default registers 4 to 7), bit 31 is the lock value, bit 30 is its enable and bits 29:0 are the data. The data part of such a write is judged against the lock state held before that write. Reads return {lock, 0, data}, and `cfg_data` carries 0 in bits 31:30.
- R6: Writing 1 to bit 0 of the protection register enters `SEAL_SHUT`. Writing 0 to it has no effect, and only reset clears it. It reads back as bit 0.
- R7: In `SEAL_SHUT`, any write that sets one or more lock enable bits is refused as a whole.
- R8: Entering `SEAL_SHUT` keeps the current soft lock values, so registers that are unlocked stay writable.
- R9: A refused write changes no state and raises `wr_rejected` for exactly the one cycle after its clock edge. Accepted writes never raise it.
- R10: Reset clears all contents, all soft locks and the hard lock. Writes to addresses above N+1 are ignored without a pulse, and reads from those addresses return 0.
- R11: A configuration register changes only on an accepted write addressed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| cfg_data | output | NUM_REGS*DATA_W | Contents of all configuration registers, register i at bits [i*DATA_W +: DATA_W] |
| wr_rejected | output | 1 | One-cycle pulse after a refused write |

## Verification
A soft lock that has drifted from its correct value shows up in two ways. A read of the lock register returns the wrong value at once, without waiting for a clock. The next write to that register is accepted or refused the wrong way, which shows on `wr_rejected` and `cfg_data` one cycle after that write. A hard lock stuck in the wrong state cannot be seen on `cfg_data` until a lock change is attempted. It can, however, be read back directly at the protection address, so the bench reads it after every step that could move it. The stimulus table walks locking, unlocking, inline combined writes and sealing in an order where each stale state changes a later result.

// File: rtl/regprot_pkg.sv
package regprot_pkg;
    // bit of the protection register that seals all soft locks
    localparam int SEAL_BIT = 0;
    // first enable bit in the lock register
    localparam int EN_BASE  = 16;

    typedef enum logic {
        SEAL_OPEN = 1'b0,
        SEAL_SHUT = 1'b1
    } seal_t;
endpackage

// File: rtl/regprot_decode.sv
module regprot_decode
    import regprot_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter logic [15:0] INLINE_MASK = 16'h00F0
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_REGS-1:0] data_sel,
    output logic [NUM_REGS-1:0] lk_en,
    output logic [NUM_REGS-1:0] lk_val,
    output logic                seal_req
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] PROT_ADDR = ADDR_W'(NUM_REGS + 1);

    logic lock_hit;

    always_comb begin
        lock_hit = wr_en && (wr_addr == LOCK_ADDR);
        seal_req = wr_en && (wr_addr == PROT_ADDR) && wr_data[SEAL_BIT];
        for (int i = 0; i < NUM_REGS; i++) begin
            data_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
            if (lock_hit) begin
                lk_en[i]  = wr_data[EN_BASE + i];
                lk_val[i] = wr_data[i];
            end else if (INLINE_MASK[i] && data_sel[i]) begin
                lk_en[i]  = wr_data[DATA_W-2];
                lk_val[i] = wr_data[DATA_W-1];
            end else begin
                lk_en[i]  = 1'b0;
                lk_val[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/regprot_lockctl.sv
module regprot_lockctl
    import regprot_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] data_sel,
    input  logic [NUM_REGS-1:0] lk_en,
    input  logic [NUM_REGS-1:0] lk_val,
    input  logic                seal_req,
    output logic [NUM_REGS-1:0] soft_lock,
    output logic                sealed,
    output logic                commit,
    output logic                wr_rejected
);
    seal_t seal_q, seal_d;
    logic  data_block, lock_block;

    // state register
    always_ff @(posedge clk) begin
        if (rst) seal_q <= SEAL_OPEN;
        else     seal_q <= seal_d;
    end

    always_comb begin
        unique case (seal_q)
            SEAL_OPEN: seal_d = seal_req ? SEAL_SHUT : SEAL_OPEN;
            SEAL_SHUT: seal_d = SEAL_SHUT;
            default:   seal_d = SEAL_OPEN;
        endcase
    end

    // outputs of the seal machine and the refusal decision
    always_comb begin
        sealed     = (seal_q == SEAL_SHUT);
        data_block = |(data_sel & soft_lock);
        lock_block = sealed && (|lk_en);
        commit     = !(data_block || lock_block);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_lock   <= '0;
            wr_rejected <= 1'b0;
        end else begin
            wr_rejected <= data_block || lock_block;
            if (commit) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (lk_en[i]) soft_lock[i] <= lk_val[i];
                end
            end
        end
    end

    // R6
    hard_lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sealed |=> sealed);
    // R7
    sealed_locks_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        sealed |=> $stable(soft_lock));
    // R3
    no_enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_en == '0) |=> $stable(soft_lock));
endmodule

// File: rtl/regprot_bank.sv
module regprot_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W = 32,
    parameter logic [15:0] INLINE_MASK = 16'h00F0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_REGS-1:0]          we,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_REGS*DATA_W-1:0]   cfg_data
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (INLINE_MASK[g]) begin : g_inline
            always_ff @(posedge clk) begin
                if (rst)        regs[g] <= '0;
                else if (we[g]) regs[g] <= {2'b00, wr_data[DATA_W-3:0]};
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)        regs[g] <= '0;
                else if (we[g]) regs[g] <= wr_data;
            end
        end
        assign cfg_data[g*DATA_W +: DATA_W] = regs[g];

        // R11
        reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !we[g] |=> $stable(regs[g]));
    end
endmodule

// File: rtl/regprot_top.sv
module regprot_top
    import regprot_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W = 32,
    parameter logic [15:0] INLINE_MASK = 16'h00F0,
    localparam int ADDR_W = $clog2(NUM_REGS + 2)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] cfg_data,
    output logic                       wr_rejected
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] PROT_ADDR = ADDR_W'(NUM_REGS + 1);

    if (NUM_REGS < 4 || NUM_REGS > 16 || DATA_W < 32) begin : g_bad_cfg
        $error("regprot_top: unsupported parameter set");
    end

    logic [NUM_REGS-1:0] data_sel, lk_en, lk_val, soft_lock;
    logic                seal_req, sealed, commit;

    regprot_decode #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INLINE_MASK(INLINE_MASK)
    ) u_decode (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .data_sel(data_sel), .lk_en(lk_en), .lk_val(lk_val), .seal_req(seal_req)
    );

    regprot_lockctl #(.NUM_REGS(NUM_REGS)) u_lockctl (
        .clk(clk), .rst(rst), .data_sel(data_sel), .lk_en(lk_en), .lk_val(lk_val),
        .seal_req(seal_req), .soft_lock(soft_lock), .sealed(sealed),
        .commit(commit), .wr_rejected(wr_rejected)
    );

    regprot_bank #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .INLINE_MASK(INLINE_MASK)
    ) u_bank (
        .clk(clk), .rst(rst), .we(data_sel & {NUM_REGS{commit}}),
        .wr_data(wr_data), .cfg_data(cfg_data)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                if (INLINE_MASK[i])
                    rd_data = {soft_lock[i], 1'b0, cfg_data[i*DATA_W +: DATA_W-2]};
                else
                    rd_data = cfg_data[i*DATA_W +: DATA_W];
            end
        end
        if (rd_addr == LOCK_ADDR) rd_data = DATA_W'(soft_lock);
        if (rd_addr == PROT_ADDR) rd_data = DATA_W'(sealed);
    end

    // R1
    locked_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|(data_sel & soft_lock)) |=> $stable(cfg_data));
    // R9
    reject_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_rejected |-> $past(wr_en));
endmodule

// File: tb/tb_regprot_top.sv
`timescale 1ns/1ps
module tb_regprot_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [255:0] cfg_data;
    logic        wr_rejected;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    regprot_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_data(cfg_data), .wr_rejected(wr_rejected)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic [31:0] data;
        logic        rej;
        logic [3:0]  raddr;
        logic [31:0] rdata;
        logic [3:0]  req;
    } vec_t;

    // address map: 0..7 registers (4..7 inline), 8 lock register, 9 protection
    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{4'd0,  32'hAAAA5555, 1'b0, 4'd0, 32'hAAAA5555, 4'd1},  // R1 plain write
        '{4'd8,  32'h00010001, 1'b0, 4'd8, 32'h00000001, 4'd2},  // R2 lock reg0
        '{4'd0,  32'h12345678, 1'b1, 4'd0, 32'hAAAA5555, 4'd1},  // R1 refused
        '{4'd8,  32'h00000000, 1'b0, 4'd8, 32'h00000001, 4'd3},  // R3 no enable
        '{4'd8,  32'h00010000, 1'b0, 4'd8, 32'h00000000, 4'd4},  // R4 release
        '{4'd0,  32'h12345678, 1'b0, 4'd0, 32'h12345678, 4'd4},  // R4 writable again
        '{4'd4,  32'hC00000AB, 1'b0, 4'd4, 32'h800000AB, 4'd5},  // R5 combined write
        '{4'd4,  32'h00000011, 1'b1, 4'd4, 32'h800000AB, 4'd1},  // R1 inline locked
        '{4'd1,  32'h0000000F, 1'b0, 4'd8, 32'h00000010, 4'd5},  // R5 lock visible
        '{4'd5,  32'h80000022, 1'b0, 4'd5, 32'h00000022, 4'd3},  // R3 inline no enable
        '{4'd9,  32'h00000001, 1'b0, 4'd9, 32'h00000001, 4'd6},  // R6 seal
        '{4'd8,  32'h00020002, 1'b1, 4'd8, 32'h00000010, 4'd7},  // R7 frozen
        '{4'd1,  32'h00000BEE, 1'b0, 4'd1, 32'h00000BEE, 4'd8},  // R8 still writable
        '{4'd9,  32'h00000000, 1'b0, 4'd9, 32'h00000001, 4'd6},  // R6 no clear
        '{4'd4,  32'h40000000, 1'b1, 4'd4, 32'h800000AB, 4'd9},  // R9 refused unlock
        '{4'd6,  32'hC0000033, 1'b1, 4'd6, 32'h00000000, 4'd7},  // R7 inline lock sealed
        '{4'd10, 32'hDEADBEEF, 1'b0, 4'd0, 32'h12345678, 4'd10}  // R10 out of range
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input logic [3:0] a, input logic [31:0] exp, input string what);
        rd_addr = a;
        #1;
        check(rd_data, exp, what);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(cfg_data[31:0], 32'h0, "R10 reset cfg reg0");
        check(32'(|cfg_data), 32'h0, "R10 reset cfg all");
        check(32'(wr_rejected), 32'h0, "R10 reset pulse");
        read_check(4'd8, 32'h0, "R10 reset lock reg");
        read_check(4'd9, 32'h0, "R10 reset protection");

        for (int k = 0; k < NV; k++) begin
            do_write(TBL[k].addr, TBL[k].data);
            check(32'(wr_rejected), 32'(TBL[k].rej),
                  $sformatf("R%0d step %0d reject flag", TBL[k].req, k));
            read_check(TBL[k].raddr, TBL[k].rdata,
                  $sformatf("R%0d step %0d readback", TBL[k].req, k));
        end

        // R5 inline register output has top bits clear; R8 plain register output
        check(cfg_data[4*32 +: 32], 32'h000000AB, "R5 cfg inline reg4");
        check(cfg_data[1*32 +: 32], 32'h00000BEE, "R8 cfg reg1");
        // R10 out-of-range read
        read_check(4'd15, 32'h0, "R10 out of range read");

        // R9 pulse lasts one cycle
        do_write(4'd0, 32'h0);
        do_write(4'd4, 32'h1);
        check(32'(wr_rejected), 32'h1, "R9 pulse present");
        @(negedge clk);
        check(32'(wr_rejected), 32'h0, "R9 pulse one cycle");

        // R10 reset clears the hard lock and everything else
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        read_check(4'd9, 32'h0, "R10 hard lock cleared");
        read_check(4'd8, 32'h0, "R10 soft locks cleared");
        check(32'(|cfg_data), 32'h0, "R10 contents cleared");

        // R4 lock all after reset, then R1 refused write
        do_write(4'd8, 32'h00FF00FF);
        check(32'(wr_rejected), 32'h0, "R4 lock all accepted");
        read_check(4'd8, 32'h000000FF, "R4 lock all readback");
        do_write(4'd3, 32'h55);
        check(32'(wr_rejected), 32'h1, "R1 reg3 refused");
        check(cfg_data[3*32 +: 32], 32'h0, "R1 reg3 unchanged");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule